// File: doc/BRIEF.md
# Inbound Message Frame Ring Controller

This block keeps track of a circular ring of fixed 4 KB inbound message frames held in system memory. Each time the link side reports a received message, the controller works out where the next frame belongs from its enqueue pointer, asks a memory writer to store it through a request/acknowledge port, and moves the enqueue pointer on by one slot once the writer acknowledges. Software finds the oldest unread frame through the dequeue pointer and, after consuming it, releases the slot by writing a self-clearing increment bit in the mode register.

Three sticky status flags are kept: a message-in-queue interrupt, a queue-full flag set when a message had to be discarded, and a reception-error flag. Each is cleared by writing one to its bit. The ring size is a power of two from 2 to 2048 slots, and one slot always stays unused so that equal pointers mean an empty ring.

Top module: `iq_frame_queue`

## Requirements
- R1: After reset, every readable register is zero, fw_req is low and the three flag outputs are low.
- R2: Writing the ring base register (address 2) loads the base and sets both the dequeue pointer (address 3) and the enqueue pointer (address 4) equal to that base, so the ring is empty.
- R3: With the unit enabled (mode bit 0) and the ring not full, a message strobe without error raises fw_req on the next clock with fw_addr equal to the enqueue pointer; fw_req and fw_addr hold until fw_ack, after which the enqueue pointer has moved up by 4096 bytes and status bit 0 is set.
- R4: The ring holds 2^(code+1) slots, where code is mode bits [15:12] (values above 10 act as 10); a pointer leaving the last slot returns to the base.
- R5: A good message arriving while the enqueue pointer plus one slot would equal the dequeue pointer is discarded with no request, and status bit 4 is set.
- R6: A message strobe with msg_err high causes no request and no pointer change, and sets status bit 7.
- R7: While mode bit 0 is low, message strobes have no effect on pointers, status or fw_req.
- R8: Message strobes arriving while a frame request is still unacknowledged are ignored.
- R9: Writing mode bit 1 moves the dequeue pointer on by one slot if the ring is not empty and does nothing when it is empty; bit 1 always reads back as zero.
- R10: Status bits 7, 4 and 0 (address 1) are each cleared by writing one to them; outputs err_flag, full_flag and irq_msg follow those bits.
- R11: A slot release that leaves the ring still not empty sets status bit 0 again.
- R12: reg_rdata presents the addressed register on the clock after reg_re: address 0 mode, 1 status, 2 base, 3 dequeue pointer, 4 enqueue pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| msg_valid | input | 1 | One-cycle received-message strobe |
| msg_err | input | 1 | Marks the strobed message as failed |
| fw_req | output | 1 | Frame write request |
| fw_addr | output | ADDR_W | Memory address of the frame to be written |
| fw_ack | input | 1 | Frame write completed |
| irq_msg | output | 1 | Message-in-queue interrupt |
| full_flag | output | 1 | A message was discarded because the ring was full |
| err_flag | output | 1 | A reception error was reported |

## Verification
A register write or message strobe takes effect at the rising edge where it is sampled, so pointers and flags are compared one cycle later; a read result is due on the clock after reg_re. fw_req and fw_addr appear one cycle after the strobe and are checked then and during every wait cycle, while the enqueue pointer and interrupt are due one cycle after the edge that sees fw_ack. The bench drives on falling edges and samples just before the next falling edge so that each result is observed exactly in the cycle it becomes due.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_STAT = 3'd1,
    RA_BASE = 3'd2,
    RA_DEQ  = 3'd3,
    RA_ENQ  = 3'd4
  } reg_addr_e;

  localparam int MD_EN       = 0;
  localparam int MD_DEQ_INC  = 1;
  localparam int MD_SIZE_LSB = 12;
  localparam int MD_SIZE_W   = 4;

  localparam int ST_MSG  = 0;
  localparam int ST_FULL = 4;
  localparam int ST_ERR  = 7;

  typedef enum logic {WS_IDLE = 1'b0, WS_REQ = 1'b1} wr_state_e;
endpackage

// File: rtl/iq_ring_idx.sv
module iq_ring_idx #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] mask,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (adv)   idx <= (idx + IDX_W'(1)) & mask;
  end
endmodule

// File: rtl/iq_regs.sv
module iq_regs
  import iq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [2:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [ADDR_W-1:0]    deq_ptr,
  input  logic [ADDR_W-1:0]    enq_ptr,
  input  logic                 set_msg,
  input  logic                 set_full,
  input  logic                 set_err,
  output logic                 mode_en,
  output logic [MD_SIZE_W-1:0] size_code,
  output logic [ADDR_W-1:0]    base_addr,
  output logic                 deq_inc_req,
  output logic                 base_load,
  output logic                 st_msg,
  output logic                 st_full,
  output logic                 st_err
);
  logic wr_mode, wr_stat;
  logic [DATA_W-1:0] rd_mux;

  assign wr_mode     = reg_we && (reg_addr == RA_MODE);
  assign wr_stat     = reg_we && (reg_addr == RA_STAT);
  assign base_load   = reg_we && (reg_addr == RA_BASE);
  assign deq_inc_req = wr_mode && reg_wdata[MD_DEQ_INC];

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_MODE: begin
        rd_mux[MD_EN] = mode_en;
        rd_mux[MD_SIZE_LSB +: MD_SIZE_W] = size_code;
      end
      RA_STAT: begin
        rd_mux[ST_MSG]  = st_msg;
        rd_mux[ST_FULL] = st_full;
        rd_mux[ST_ERR]  = st_err;
      end
      RA_BASE: rd_mux = DATA_W'(base_addr);
      RA_DEQ:  rd_mux = DATA_W'(deq_ptr);
      RA_ENQ:  rd_mux = DATA_W'(enq_ptr);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_en   <= 1'b0;
      size_code <= '0;
      base_addr <= '0;
      st_msg    <= 1'b0;
      st_full   <= 1'b0;
      st_err    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_mode) begin
        mode_en   <= reg_wdata[MD_EN];
        size_code <= reg_wdata[MD_SIZE_LSB +: MD_SIZE_W];
      end
      if (base_load) base_addr <= ADDR_W'(reg_wdata);
      st_msg  <= set_msg  | (st_msg  & ~(wr_stat & reg_wdata[ST_MSG]));
      st_full <= set_full | (st_full & ~(wr_stat & reg_wdata[ST_FULL]));
      st_err  <= set_err  | (st_err  & ~(wr_stat & reg_wdata[ST_ERR]));
      if (reg_re) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/iq_wr_ctrl.sv
module iq_wr_ctrl
  import iq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic              msg_err,
  input  logic              enable,
  input  logic              q_full,
  input  logic [ADDR_W-1:0] enq_ptr,
  input  logic              fw_ack,
  output logic              fw_req,
  output logic [ADDR_W-1:0] fw_addr,
  output logic              commit,
  output logic              err_hit,
  output logic              drop_hit
);
  wr_state_e state;
  logic      take;

  assign take     = (state == WS_IDLE) && msg_valid && enable;
  assign err_hit  = take && msg_err;
  assign drop_hit = take && !msg_err && q_full;
  assign commit   = (state == WS_REQ) && fw_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WS_IDLE;
      fw_req  <= 1'b0;
      fw_addr <= '0;
    end else begin
      case (state)
        WS_IDLE: if (take && !msg_err && !q_full) begin
          state   <= WS_REQ;
          fw_req  <= 1'b1;
          fw_addr <= enq_ptr;
        end
        WS_REQ: if (fw_ack) begin
          state  <= WS_IDLE;
          fw_req <= 1'b0;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iq_frame_queue.sv
module iq_frame_queue
  import iq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FRAME_BYTES = 4096,
  parameter int MAX_ENTRIES = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              msg_valid,
  input  logic              msg_err,
  output logic              fw_req,
  output logic [ADDR_W-1:0] fw_addr,
  input  logic              fw_ack,
  output logic              irq_msg,
  output logic              full_flag,
  output logic              err_flag
);
  localparam int IDX_W       = $clog2(MAX_ENTRIES);
  localparam int FRAME_SHIFT = $clog2(FRAME_BYTES);
  localparam int MAX_CODE    = IDX_W - 1;

  logic                 mode_en, deq_inc_req, base_load;
  logic [MD_SIZE_W-1:0] size_code, code_eff;
  logic [ADDR_W-1:0]    base_addr, deq_ptr, enq_ptr;
  logic [IDX_W:0]       span;
  logic [IDX_W-1:0]     mask, enq_idx, deq_idx;
  logic                 q_full, q_empty, deq_adv, more_left;
  logic                 commit, err_hit, drop_hit, set_msg;

  assign code_eff = (size_code > MD_SIZE_W'(MAX_CODE)) ? MD_SIZE_W'(MAX_CODE) : size_code;
  assign span     = (IDX_W+1)'(1) << (code_eff + MD_SIZE_W'(1));
  assign mask     = IDX_W'(span - (IDX_W+1)'(1));

  assign q_empty   = (enq_idx == deq_idx);
  assign q_full    = (((enq_idx + IDX_W'(1)) & mask) == deq_idx);
  assign more_left = (((deq_idx + IDX_W'(1)) & mask) != enq_idx);
  assign deq_adv   = deq_inc_req && !q_empty;
  assign set_msg   = commit || (deq_adv && more_left);

  assign enq_ptr = base_addr + (ADDR_W'(enq_idx) << FRAME_SHIFT);
  assign deq_ptr = base_addr + (ADDR_W'(deq_idx) << FRAME_SHIFT);

  iq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .deq_ptr, .enq_ptr,
    .set_msg, .set_full(drop_hit), .set_err(err_hit),
    .mode_en, .size_code, .base_addr, .deq_inc_req, .base_load,
    .st_msg(irq_msg), .st_full(full_flag), .st_err(err_flag)
  );

  iq_ring_idx #(.IDX_W(IDX_W)) u_enq (
    .clk, .rst, .clr(base_load), .adv(commit), .mask, .idx(enq_idx)
  );

  iq_ring_idx #(.IDX_W(IDX_W)) u_deq (
    .clk, .rst, .clr(base_load), .adv(deq_adv), .mask, .idx(deq_idx)
  );

  iq_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk, .rst, .msg_valid, .msg_err, .enable(mode_en), .q_full, .enq_ptr,
    .fw_ack, .fw_req, .fw_addr, .commit, .err_hit, .drop_hit
  );
endmodule

// File: rtl/iq_frame_queue_chk.sv
module iq_frame_queue_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              msg_valid,
  input logic              msg_err,
  input logic              fw_req,
  input logic [ADDR_W-1:0] fw_addr,
  input logic              fw_ack,
  input logic              full_flag,
  input logic              err_flag,
  input logic              mode_en,
  input logic              q_full,
  input logic              q_empty,
  input logic [IDX_W-1:0]  enq_idx,
  input logic [IDX_W-1:0]  deq_idx
);
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (fw_req && !fw_ack) |=> (fw_req && $stable(fw_addr)));

  a_r3_enq_step: assert property (@(posedge clk) disable iff (rst)
    (fw_req && fw_ack && !(reg_we && reg_addr == 3'd2)) |=> (enq_idx != $past(enq_idx)));

  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (!fw_req && msg_valid && !msg_err && mode_en && q_full) |=> (!fw_req && full_flag));

  a_r6_err_flag: assert property (@(posedge clk) disable iff (rst)
    (!fw_req && msg_valid && msg_err && mode_en) |=> (!fw_req && err_flag));

  a_r9_empty_release: assert property (@(posedge clk) disable iff (rst)
    (q_empty && reg_we && reg_addr == 3'd0 && reg_wdata[1]) |=> $stable(deq_idx));
endmodule

bind iq_frame_queue iq_frame_queue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .msg_valid(msg_valid), .msg_err(msg_err), .fw_req(fw_req), .fw_addr(fw_addr),
  .fw_ack(fw_ack), .full_flag(full_flag), .err_flag(err_flag), .mode_en(mode_en),
  .q_full(q_full), .q_empty(q_empty), .enq_idx(enq_idx), .deq_idx(deq_idx)
);

// File: tb/iq_frame_queue_tb.sv
module iq_frame_queue_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid = 1'b0, msg_err = 1'b0;
  logic        fw_req, fw_ack = 1'b0;
  logic [31:0] fw_addr;
  logic        irq_msg, full_flag, err_flag;

  int checks = 0;
  int errors = 0;

  // model state
  logic [31:0] m_base = '0;
  int          m_code = 0;
  bit          m_en = 0;
  int          m_enq = 0, m_deq = 0;
  bit          m_msg = 0, m_full = 0, m_err = 0;

  always #2 clk = ~clk;

  iq_frame_queue u_dut (
    .clk, .rst, .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata,
    .msg_valid, .msg_err, .fw_req, .fw_addr, .fw_ack,
    .irq_msg, .full_flag, .err_flag
  );

  function automatic int m_mask();
    return (1 << (m_code + 1)) - 1;
  endfunction

  function automatic logic [31:0] m_ptr(int idx);
    return m_base + (32'(idx) << 12);
  endfunction

  function automatic bit m_is_full();
    return ((m_enq + 1) & m_mask()) == m_deq;
  endfunction

  function automatic logic [31:0] m_status();
    return {24'd0, m_err, 2'b00, m_full, 3'b000, m_msg};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic verify(string req);
    logic [31:0] v;
    chk(fw_req == 1'b0, req, "fw_req idle", 32'(fw_req), 0);
    chk(irq_msg == m_msg, "R10", "irq_msg pin", 32'(irq_msg), 32'(m_msg));
    chk(full_flag == m_full, "R10", "full_flag pin", 32'(full_flag), 32'(m_full));
    chk(err_flag == m_err, "R10", "err_flag pin", 32'(err_flag), 32'(m_err));
    reg_read(3'd1, v); chk(v == m_status(), req, "status R12", v, m_status());
    reg_read(3'd3, v); chk(v == m_ptr(m_deq), req, "dequeue ptr", v, m_ptr(m_deq));
    reg_read(3'd4, v); chk(v == m_ptr(m_enq), req, "enqueue ptr", v, m_ptr(m_enq));
  endtask

  task automatic set_mode(bit en, int code);
    m_en = en; m_code = code;
    reg_write(3'd0, (32'(code) << 12) | 32'(en));
  endtask

  task automatic load_base(logic [31:0] b);
    m_base = b; m_enq = 0; m_deq = 0;
    reg_write(3'd2, b);
  endtask

  task automatic release_slot();
    reg_write(3'd0, (32'(m_code) << 12) | 32'h2 | 32'(m_en));
    if (m_enq != m_deq) begin
      if (((m_deq + 1) & m_mask()) != m_enq) m_msg = 1;
      m_deq = (m_deq + 1) & m_mask();
    end
  endtask

  task automatic clear_status(logic [31:0] v);
    reg_write(3'd1, v);
    if (v[0]) m_msg = 0;
    if (v[4]) m_full = 0;
    if (v[7]) m_err = 0;
  endtask

  // one message; delay = wait cycles before ack; poke = extra strobe while pending
  task automatic deliver(bit err, int delay, bit poke, string req);
    bit accept;
    accept = m_en && !err && !m_is_full();
    msg_valid = 1'b1; msg_err = err;
    @(negedge clk);
    msg_valid = 1'b0; msg_err = 1'b0;
    if (accept) begin
      chk(fw_req == 1'b1, req, "fw_req raised", 32'(fw_req), 1);
      chk(fw_addr == m_ptr(m_enq), req, "fw_addr", fw_addr, m_ptr(m_enq));
      for (int i = 0; i < delay; i++) begin
        if (poke && i == 0) begin msg_valid = 1'b1; msg_err = 1'b0; end
        @(negedge clk);
        msg_valid = 1'b0;
        chk(fw_req == 1'b1 && fw_addr == m_ptr(m_enq), req, "request held", fw_addr, m_ptr(m_enq));
      end
      fw_ack = 1'b1;
      @(negedge clk);
      fw_ack = 1'b0;
      chk(fw_req == 1'b0, req, "fw_req dropped after ack", 32'(fw_req), 0);
      m_enq = (m_enq + 1) & m_mask();
      m_msg = 1;
    end else begin
      chk(fw_req == 1'b0, req, "no request", 32'(fw_req), 0);
      if (m_en) begin
        if (err) m_err = 1;
        else     m_full = 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(fw_req == 0 && irq_msg == 0 && full_flag == 0 && err_flag == 0, "R1", "pins after reset",
        {fw_req, irq_msg, full_flag, err_flag}, 0);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), v);
      chk(v == 0, "R1", "register after reset", v, 0);
    end

    // R2 base load
    load_base(32'h8000_0000);
    reg_read(3'd2, v); chk(v == 32'h8000_0000, "R2", "base readback", v, 32'h8000_0000);
    verify("R2");

    // R7 disabled
    deliver(0, 0, 0, "R7");
    deliver(1, 0, 0, "R7");
    verify("R7");

    // R3 accepted message, 4-slot ring
    set_mode(1, 1);
    reg_read(3'd0, v); chk(v == 32'h0000_1001, "R12", "mode readback", v, 32'h0000_1001);
    deliver(0, 0, 0, "R3");
    verify("R3");
    clear_status(32'h91);
    verify("R10");

    // R5 fill to capacity then drop
    deliver(0, 2, 0, "R3");
    deliver(0, 1, 0, "R3");
    deliver(0, 0, 0, "R5");
    verify("R5");
    chk(full_flag == 1, "R5", "full flag set", 32'(full_flag), 1);

    // R6 error strobe
    deliver(1, 0, 0, "R6");
    verify("R6");

    // R11 release leaves ring non-empty
    clear_status(32'h01);
    release_slot();
    chk(irq_msg == 1, "R11", "irq re-set after release", 32'(irq_msg), 1);
    reg_read(3'd0, v); chk(v[1] == 0, "R9", "increment bit reads zero", v, 32'h1001);
    verify("R11");
    clear_status(32'h91);
    release_slot();
    release_slot();
    verify("R9");
    release_slot();   // empty: ignored
    verify("R9");

    // R4 wrap: enq is at slot 3, next accepted goes to base
    chk(m_enq == 3, "R4", "model at last slot", 32'(m_enq), 3);
    deliver(0, 0, 0, "R4");
    reg_read(3'd4, v); chk(v == 32'h8000_0000, "R4", "enqueue wrapped", v, 32'h8000_0000);
    release_slot();
    reg_read(3'd3, v); chk(v == 32'h8000_0000, "R4", "dequeue wrapped", v, 32'h8000_0000);
    verify("R4");

    // R8 strobe during pending request ignored
    deliver(0, 3, 1, "R8");
    verify("R8");

    // 2-slot ring: one frame fills it
    load_base(32'h0010_0000);
    set_mode(1, 0);
    clear_status(32'h91);
    deliver(0, 0, 0, "R4");
    deliver(0, 0, 0, "R5");
    verify("R5");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4)      deliver(($urandom_range(0, 7) == 0), int'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), "R3");
      else if (op < 7) release_slot();
      else if (op < 8) clear_status($urandom & 32'h91);
      else if (op < 9) verify("R12");
      else if ($urandom_range(0, 7) == 0) begin
        load_base({$urandom_range(0, 255), 24'h0});
        set_mode(($urandom_range(0, 5) != 0), int'($urandom_range(0, 3)));
      end
    end
    verify("R12");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule